// File: doc/BRIEF.md
# Dual-Window Watchdog Reset Generator

This block watches a processor through one watchdog line and pulls a supervisory reset low when the processor stops servicing it. Any change of level on the watchdog line, rising or falling, counts as service and restarts the timeout count. When the count runs out, the block holds its active-low reset output low for a fixed number of millisecond ticks. It then releases the reset and starts counting again.

Two timeout windows are used. After every reset pulse, and after a system reset, the block allows the long startup window. This gives the software time to boot. The first service edge seen after reset is released switches it to the short normal window. A fixed-long mode keeps the long window in use at all times. The watchdog is idle with its count cleared while the enable input is low, which stands for an undriven watchdog line. It is also idle while the power-good input is low. All durations are counted in strobes of a one-cycle millisecond tick supplied by the surrounding chip.

Top module: `wdt_dual_window`

## Requirements
- R1: After system reset (rst_n low on a clock edge) the output sup_rst_n is high, the long window is selected and the count is zero.
- R2: With the watchdog enabled and no service, sup_rst_n goes low on the clock edge of the L-th tick after the count restarts. L is LONG_TICKS (default 1000) in the long window and SHORT_TICKS (default 70) in the normal window. With tick_ms high every cycle, the output is low L clock edges after the restart edge.
- R3: Each reset pulse holds sup_rst_n low for exactly PULSE_TICKS ticks (default 35; 140 is the alternative setting).
- R4: Every release of the reset pulse restarts the count from zero in the long window. If wdi_raw never changes, pulses repeat with LONG_TICKS high followed by PULSE_TICKS low.
- R5: A rising or a falling change on wdi_raw while the output is high restarts the count. The line passes two synchronizer flops and one edge-compare flop, so the restart takes effect on the third clock edge after the change, and regular service keeps sup_rst_n high.
- R6: The first service edge after a release selects the normal window (SHORT_TICKS). That window stays selected until the next reset pulse.
- R7: Changes on wdi_raw while sup_rst_n is low are ignored and do not select the normal window.
- R8: While wd_en is low the count is held at zero, no pulse is issued and edges are ignored. After wd_en returns high, expiry comes L ticks later.
- R9: While pwr_good is low the watchdog behaves exactly as with wd_en low.
- R10: The count advances only in cycles where tick_ms is high. With tick_ms low, no pulse is issued.
- R11: With FIXED_LONG set to 1, the timeout is LONG_TICKS even after service edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| wdi_raw | input | 1 | Watchdog service line, asynchronous |
| wd_en | input | 1 | Watchdog enable; low when the line is undriven |
| pwr_good | input | 1 | Supply-above-threshold indication |
| sup_rst_n | output | 1 | Active-low supervisory reset |

## Verification
The main timeout function is tried with three input patterns. A line that never toggles must give the periodic long-window pulse train. A single toggle must separate the short window from the long one by the exact expiry distance. Toggling every 50 cycles must hold the output high indefinitely. A toggle placed inside a reset pulse tells an ignored edge apart from one that wrongly switches the window. Holding tick_ms, wd_en and pwr_good low for thousands of cycles, with exact expiry timing once they return, separates a count that is frozen from one that is cleared. A second instance with a 140-tick pulse and the fixed-long mode shows that one toggle leaves the timeout at the long value.

// File: rtl/wdt_pkg.sv
// Package: shared types and sizing helpers for the dual-window watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdt_pkg;

    // Run/hold phase of the watchdog sequencer.
    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_HOLD = 1'b1
    } wdt_phase_e;

    // Larger of two unsigned values, used to size the shared counter.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
// Module: brings the asynchronous watchdog line into the clock domain and
// flags any change of level (rising or falling) as a one-cycle pulse.
// Assumes: the line is held at its reset value (0) while rst_n is low.
module wdt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic edge_seen
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchronizer followed by a history flop for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Any difference between current and previous synchronized level is an edge.
    always_comb edge_seen = sync_q ^ prev_q;

endmodule

// File: rtl/wdt_window.sv
// Module: remembers which timeout window is active and presents its length.
// Long after reset or any expiry; short after the first qualified service edge.
// Assumes: svc is already qualified (running phase, watchdog enabled).
module wdt_window #(
    parameter int unsigned LONG_TICKS  = 1000,
    parameter int unsigned SHORT_TICKS = 70,
    parameter int unsigned CW          = 10,
    parameter bit          FIXED_LONG  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          svc,
    input  logic          expire,
    input  logic          in_hold,
    output logic          use_long,
    output logic [CW-1:0] limit
);
    // Window flag: expiry forces long, service selects short unless fixed-long.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_long <= 1'b1;
        end else if (expire) begin
            use_long <= 1'b1;
        end else if (svc) begin
            use_long <= FIXED_LONG;
        end
    end

    // Present the active window length in ticks.
    always_comb limit = use_long ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);

    // R7: the long window persists throughout a reset pulse whatever the line does.
    p_hold_keeps_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold |=> use_long);

    generate
        if (FIXED_LONG) begin : g_fixed
            // R11: fixed-long mode never leaves the long window.
            p_fixed_long_r11: assert property (@(posedge clk) disable iff (!rst_n)
                svc |=> use_long);
        end
    endgenerate

endmodule

// File: rtl/wdt_sequencer.sv
// Module: the run/hold state machine with one shared tick counter.
// In run it counts ticks toward the window limit; in hold it times the
// reset pulse. Service or a disabled watchdog clears the count.
// Assumes: limit >= 1 and PULSE_TICKS >= 2.
module wdt_sequencer
    import wdt_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 35,
    parameter int unsigned CW          = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enabled,
    input  logic          svc,
    input  logic [CW-1:0] limit,
    output logic          in_hold,
    output logic          expire
);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);

    wdt_phase_e    phase_q;
    logic [CW-1:0] cnt_q;
    logic          pulse_done;

    // Expiry: last tick of the window while running, enabled and unserviced.
    always_comb begin
        expire     = (phase_q == PH_RUN) && enabled && !svc && tick
                     && (cnt_q >= limit - CW'(1));
        pulse_done = (phase_q == PH_HOLD) && tick && (cnt_q >= PULSE_LAST);
        in_hold    = (phase_q == PH_HOLD);
    end

    // Phase and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_RUN: begin
                    if (!enabled || svc) begin
                        cnt_q <= '0;
                    end else if (expire) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= '0;
                    end else if (tick) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                PH_HOLD: begin
                    if (pulse_done) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= '0;
                    end else if (tick) begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: begin
                    phase_q <= PH_RUN;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // R2: the running count never reaches the window length.
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN) |-> (cnt_q < limit));

    // R3: a pulse cannot end before its last tick.
    p_pulse_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_HOLD) && (cnt_q < PULSE_LAST)) |=> (phase_q == PH_HOLD));

    // R4: leaving hold always starts the run count from zero.
    p_release_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_RUN) && ($past(phase_q) == PH_HOLD)) |-> (cnt_q == '0));

    // R8: a disabled watchdog stays running with a cleared count.
    p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_RUN) && !enabled) |=> ((phase_q == PH_RUN) && (cnt_q == '0)));

    // R10: without a tick the running count does not move.
    p_tick_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_RUN) && enabled && !svc && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_dual_window.sv
// Module: top of the dual-window watchdog reset generator.
// Ties the line synchronizer, window selector and sequencer together and
// drives the active-low supervisory reset.
// Assumes: tick_ms is a single-cycle strobe in the clk domain.
module wdt_dual_window
    import wdt_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 1000,
    parameter int unsigned SHORT_TICKS = 70,
    parameter int unsigned PULSE_TICKS = 35,
    parameter bit          FIXED_LONG  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic wdi_raw,
    input  logic wd_en,
    input  logic pwr_good,
    output logic sup_rst_n
);
    localparam int unsigned CW = $clog2(umax(umax(LONG_TICKS, SHORT_TICKS), PULSE_TICKS) + 1);

    logic          line_edge;
    logic          enabled;
    logic          svc;
    logic          in_hold;
    logic          expire;
    logic          use_long;
    logic [CW-1:0] limit;

    // Qualify service: only while running and enabled.
    always_comb begin
        enabled   = wd_en && pwr_good;
        svc       = line_edge && enabled && !in_hold;
        sup_rst_n = !in_hold;
    end

    wdt_edge_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (wdi_raw),
        .edge_seen (line_edge)
    );

    wdt_window #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS),
        .CW          (CW),
        .FIXED_LONG  (FIXED_LONG)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc      (svc),
        .expire   (expire),
        .in_hold  (in_hold),
        .use_long (use_long),
        .limit    (limit)
    );

    wdt_sequencer #(
        .PULSE_TICKS (PULSE_TICKS),
        .CW          (CW)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .enabled (enabled),
        .svc     (svc),
        .limit   (limit),
        .in_hold (in_hold),
        .expire  (expire)
    );

    // R1: after a system reset cycle the output is released.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> sup_rst_n);

    // R9: low supply blocks any new pulse from starting.
    p_power_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_rst_n && !pwr_good) |=> sup_rst_n);

endmodule

// File: tb/tb_wdt_dual_window.sv
// Directed bench: tick_ms is held high except in the tick-gating test, so
// each tick is one clock. Two instances share stimulus: default and
// fixed-long with a 140-tick pulse.
module tb_wdt_dual_window;
    localparam int LONG  = 1000;
    localparam int SHORT = 70;
    localparam int PULSE = 35;
    localparam int PULSE2 = 140;
    localparam int SYNC_LAT = 3;
    localparam int MAXWAIT = 5000;

    logic clk = 1'b0;
    logic rst_n, tick_ms, wdi_raw, wd_en, pwr_good;
    logic out_a, out_b;
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    wdt_dual_window dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wdi_raw(wdi_raw),
        .wd_en(wd_en), .pwr_good(pwr_good), .sup_rst_n(out_a)
    );

    wdt_dual_window #(.PULSE_TICKS(PULSE2), .FIXED_LONG(1'b1)) dut_fl (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wdi_raw(wdi_raw),
        .wd_en(wd_en), .pwr_good(pwr_good), .sup_rst_n(out_b)
    );

    function automatic logic outv(input int sel);
        return (sel == 0) ? out_a : out_b;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count clock edges until the chosen output leaves level lvl.
    task automatic meas(input int sel, input logic lvl, output int n);
        n = 0;
        while (n < MAXWAIT) begin
            @(posedge clk); @(negedge clk);
            n++;
            if (outv(sel) != lvl) break;
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_ms = 1'b1; wdi_raw = 1'b0; wd_en = 1'b1; pwr_good = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic toggle();
        wdi_raw = ~wdi_raw;
    endtask

    task automatic t_reset_state();
        apply_reset();
        chk("R1 out_a after reset", out_a, 1);
        chk("R1 out_b after reset", out_b, 1);
    endtask

    task automatic t_periodic();
        int n;
        apply_reset();
        meas(0, 1'b1, n); chk("R2 first long expiry", n, LONG);
        meas(0, 1'b0, n); chk("R3 pulse width", n, PULSE);
        meas(0, 1'b1, n); chk("R4 repeat long window", n, LONG);
        meas(0, 1'b0, n); chk("R4 repeat pulse width", n, PULSE);
    endtask

    task automatic t_short_after_edge();
        int n;
        apply_reset();
        repeat (100) @(negedge clk);
        toggle();
        meas(0, 1'b1, n); chk("R6 short window after first edge", n, SHORT + SYNC_LAT);
        meas(0, 1'b0, n); chk("R3 pulse after short expiry", n, PULSE);
        meas(0, 1'b1, n); chk("R4 long window again after release", n, LONG);
    endtask

    task automatic t_service();
        int lows = 0;
        apply_reset();
        for (int i = 0; i < 40; i++) begin
            repeat (50) begin
                @(negedge clk);
                if (!out_a) lows++;
            end
            toggle();
        end
        chk("R5 regular service keeps output high", lows, 0);
        // falling then restart: last toggle above, check expiry distance
        begin
            int n;
            meas(0, 1'b1, n);
            chk("R5 restart distance after last edge", n, SHORT + SYNC_LAT);
        end
    endtask

    task automatic t_edge_in_hold();
        int n;
        apply_reset();
        repeat (10) @(negedge clk);
        toggle();
        meas(0, 1'b1, n); chk("R6 short expiry before hold test", n, SHORT + SYNC_LAT);
        repeat (3) @(negedge clk);
        toggle();
        meas(0, 1'b0, n); chk("R3 width with edge inside pulse", n, PULSE - 3);
        meas(0, 1'b1, n); chk("R7 edge in pulse ignored, long window", n, LONG);
    endtask

    task automatic t_disable();
        int lows = 0;
        int n;
        apply_reset();
        wd_en = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!out_a) lows++;
            if (i % 100 == 0) toggle();
        end
        chk("R8 no pulse while disabled", lows, 0);
        wd_en = 1'b1;
        meas(0, 1'b1, n); chk("R8 long expiry after re-enable", n, LONG);
    endtask

    task automatic t_power();
        int lows = 0;
        int n;
        apply_reset();
        repeat (500) @(negedge clk);
        pwr_good = 1'b0;
        for (int i = 0; i < 2500; i++) begin
            @(negedge clk);
            if (!out_a) lows++;
        end
        chk("R9 no pulse while power low", lows, 0);
        pwr_good = 1'b1;
        meas(0, 1'b1, n); chk("R9 count cleared by low power", n, LONG);
    endtask

    task automatic t_tick_gate();
        int lows = 0;
        int n;
        apply_reset();
        tick_ms = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!out_a) lows++;
        end
        chk("R10 no pulse without ticks", lows, 0);
        tick_ms = 1'b1;
        meas(0, 1'b1, n); chk("R10 count starts with ticks", n, LONG);
    endtask

    task automatic t_fixed_long();
        int n;
        apply_reset();
        repeat (20) @(negedge clk);
        toggle();
        meas(1, 1'b1, n); chk("R11 fixed-long expiry after edge", n, LONG + SYNC_LAT);
        meas(1, 1'b0, n); chk("R3 alternative pulse width", n, PULSE2);
    endtask

    initial begin
        rst_n = 1'b0; tick_ms = 1'b1; wdi_raw = 1'b0; wd_en = 1'b1; pwr_good = 1'b1;
        t_reset_state();
        t_periodic();
        t_short_after_edge();
        t_service();
        t_edge_in_hold();
        t_disable();
        t_power();
        t_tick_gate();
        t_fixed_long();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule